// File: doc/BRIEF.md
# Bank IO Register Block with Atomic Set/Clear Windows

This block holds the software-visible drive state of one bank of pins: an output-level register and an output-enable register, one bit per pin. It also offers a read-only view of the pin inputs after a two-flop synchroniser. Software reaches the block through a 32-bit register port. Bit n of every register belongs to pin n of the bank. The bank width is set by a pin-count parameter.

The address space has three windows, picked by address bits [13:12]. Window 0 (base offsets) replaces a whole register. Window 2 (base + 0x2000) ORs the written 1-bits into the register. Window 3 (base + 0x3000) removes the written 1-bits from it. Software can therefore change one pin's level or direction without a read-modify-write, which matters when several agents share a bank.

Software may load the output level while the pin is still an input. It then sets the enable bit, so the pin begins driving at the intended level. The `pin_out` and `pin_oe` outputs feed the function multiplexer for pins that select software-controlled mode.

Top module: `gpio_bank_rio`

## Requirements
- R1: After reset, the output register and the output-enable register are zero, so `pin_out` and `pin_oe` are zero and both registers read back as zero.
- R2: A write at offset 0x000 (window 0) replaces the output register, and a write at offset 0x004 replaces the output-enable register. The new value appears on `pin_out`/`pin_oe` and in read-back from the cycle after the write edge.
- R3: A write at offset + 0x2000 sets every register bit whose written bit is 1 and leaves every other bit unchanged.
- R4: A write at offset + 0x3000 clears every register bit whose written bit is 1 and leaves every other bit unchanged.
- R5: The input register at offset 0x008 is read-only. A write to it in any window changes neither the output register nor the output-enable register, and it does not alter what the input register reads.
- R6: A read at offset 0x008 returns `pin_in` after two clock edges of synchronisation. A change applied before a rising edge is still invisible after that one edge and is visible after the second.
- R7: Register bits at and above the pin count read as zero, and written upper bits are discarded.
- R8: Bit n maps to pin n. An enable bit of 0 means the pin is an input and 1 means it drives. `pin_out` follows the output register whatever the enable, so a level written while the pin is an input is the level driven once the enable is set.
- R9: Writes in window 1 (base + 0x1000) and writes to any offset other than 0x000, 0x004 or 0x008 have no effect, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [13:12] select the window, bits [11:0] the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NPINS | Raw pin input levels |
| pin_out | output | NPINS | Output level per pin |
| pin_oe | output | NPINS | Output enable per pin, 1 = drive |

## Verification
A wrong bit in either drive register shows at once on `pin_out` or `pin_oe`, one cycle after the write that caused it. Mistakes in the window decode therefore show up as a neighbouring bit flipping or a bit failing to change. A corrupted synchroniser stage shows as input read-back that arrives one edge early or late, or not at all, so the bench samples between the first and second edge after each input change. Upper-bit leakage and ignored writes are checked by reading back after the offending write and before any other write.

// File: rtl/gpio_bank_rio.sv
module gpio_bank_rio #(
  parameter int NPINS  = 28,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  localparam logic [11:0] OFF_OUT = 12'h000;
  localparam logic [11:0] OFF_OE  = 12'h004;
  localparam logic [11:0] OFF_IN  = 12'h008;
  localparam logic [1:0]  WIN_RAW = 2'd0;
  localparam logic [1:0]  WIN_SET = 2'd2;
  localparam logic [1:0]  WIN_CLR = 2'd3;

  logic [NPINS-1:0] out_q, oe_q, sync1_q, sync2_q;
  logic [1:0]       win;
  logic [11:0]      off;
  logic [NPINS-1:0] wmask;
  logic             we_out, we_oe;
  logic             unused_bits;

  assign win    = bus_addr[13:12];
  assign off    = bus_addr[11:0];
  assign wmask  = bus_wdata[NPINS-1:0];
  assign we_out = bus_wr && off == OFF_OUT;
  assign we_oe  = bus_wr && off == OFF_OE;
  assign unused_bits = ^{bus_wdata, bus_addr};

  function automatic logic [NPINS-1:0] apply(input logic [NPINS-1:0] cur,
                                             input logic [NPINS-1:0] m,
                                             input logic [1:0] w);
    case (w)
      WIN_RAW: apply = m;
      WIN_SET: apply = cur | m;
      WIN_CLR: apply = cur & ~m;
      default: apply = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      if (we_out) out_q <= apply(out_q, wmask, win);
      if (we_oe)  oe_q  <= apply(oe_q, wmask, win);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (off)
      OFF_OUT: bus_rdata = 32'(out_q);
      OFF_OE:  bus_rdata = 32'(oe_q);
      OFF_IN:  bus_rdata = 32'(sync2_q);
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;

  a_r2_raw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we_out && win == WIN_RAW) |=> pin_out == $past(wmask));

  a_r3_set_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
    (we_out && win == WIN_SET) |=>
      ((pin_out & $past(wmask)) == $past(wmask)) &&
      ((pin_out & ~$past(wmask)) == ($past(pin_out) & ~$past(wmask))));

  a_r4_clr_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
    (we_oe && win == WIN_CLR) |=>
      ((pin_oe & $past(wmask)) == '0) &&
      ((pin_oe & ~$past(wmask)) == ($past(pin_oe) & ~$past(wmask))));

  a_r5_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == OFF_IN) |=> $stable(pin_out) && $stable(pin_oe));

  a_r9_window1_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && win == 2'd1) |=> $stable(pin_out) && $stable(pin_oe));

endmodule

// File: tb/tb_gpio_bank_rio.sv
module tb_gpio_bank_rio;
  localparam int N = 28;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [13:0]   bus_addr = '0;
  logic          bus_wr = 0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  int tests = 0, fails = 0;

  gpio_bank_rio #(.NPINS(N), .ADDR_W(14)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    rd(14'h000, v); chk("R1 out read", v, 0);
    rd(14'h004, v); chk("R1 oe read", v, 0);
  endtask

  task automatic t_plain;
    logic [31:0] v;
    wr(14'h000, 32'h0000_A5A5);
    chk("R2 pin_out", 32'(pin_out), 32'h0000_A5A5);
    rd(14'h000, v); chk("R2 out read", v, 32'h0000_A5A5);
    wr(14'h004, 32'h0000_0003);
    chk("R2 pin_oe", 32'(pin_oe), 32'h3);
  endtask

  task automatic t_set;
    logic [31:0] v;
    wr(14'h2000, 32'h0000_0F00);
    chk("R3 out set", 32'(pin_out), 32'h0000_AFA5);
    wr(14'h2004, 32'h0000_0010);
    rd(14'h004, v); chk("R3 oe set", v, 32'h13);
  endtask

  task automatic t_clr;
    wr(14'h3000, 32'h0000_00A0);
    chk("R4 out clr", 32'(pin_out), 32'h0000_AF05);
    wr(14'h3004, 32'h0000_0001);
    chk("R4 oe clr", 32'(pin_oe), 32'h12);
  endtask

  task automatic t_preload;
    wr(14'h3004, 32'hFFFF_FFFF);
    wr(14'h000, 32'h0000_0040);
    chk("R8 level while input", 32'(pin_out), 32'h40);
    chk("R8 still input", 32'(pin_oe), 0);
    wr(14'h2004, 32'h0000_0040);
    chk("R8 pin 6 drives", 32'(pin_oe), 32'h40);
    chk("R8 level kept", 32'(pin_out), 32'h40);
  endtask

  task automatic t_input_ro;
    logic [31:0] v;
    @(negedge clk); pin_in = 28'h0000123;
    repeat (3) @(negedge clk);
    wr(14'h0008, 32'h0FFF_FFFF);
    wr(14'h2008, 32'h0FFF_FFFF);
    wr(14'h3008, 32'h0FFF_FFFF);
    rd(14'h008, v); chk("R5 input unchanged", v, 32'h123);
    chk("R5 out unchanged", 32'(pin_out), 32'h40);
    chk("R5 oe unchanged", 32'(pin_oe), 32'h40);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    @(negedge clk); pin_in = 28'h8000005;
    @(negedge clk); rd(14'h008, v); chk("R6 one edge", v, 32'h123);
    @(negedge clk); rd(14'h008, v); chk("R6 two edges", v, 32'h0800_0005);
  endtask

  task automatic t_width;
    logic [31:0] v;
    wr(14'h000, 32'hFFFF_FFFF);
    rd(14'h000, v); chk("R7 upper out bits", v, 32'h0FFF_FFFF);
    wr(14'h2004, 32'hF000_0000);
    rd(14'h004, v); chk("R7 upper oe bits", v, 32'h40);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(14'h1000, 32'h0);
    chk("R9 window1 out", 32'(pin_out), 32'h0FFF_FFFF);
    wr(14'h1004, 32'h0);
    chk("R9 window1 oe", 32'(pin_oe), 32'h40);
    wr(14'h000C, 32'h0);
    rd(14'h00C, v); chk("R9 unmapped read", v, 0);
    chk("R9 unmapped write", 32'(pin_out), 32'h0FFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_plain;
    t_set;
    t_clr;
    t_preload;
    t_input_ro;
    t_sync;
    t_width;
    t_unmapped;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule